// File: doc/BRIEF.md
# Two-wire slave memory controller

This block is the bus-side controller of a 128-byte memory that answers as a slave on a two-wire serial bus with a clock line and an open-drain data line. Both lines are oversampled by the system clock, so all state lives in one clock domain. The block finds START, STOP and repeated START, checks the select byte, loads a byte address into a 7-bit pointer and serves current-pointer, random and sequential reads through a combinational read port.

Write bytes are not stored here. Each accepted byte leaves on a one-cycle valid/address/data strobe toward a page buffer, and a commit strobe tells that buffer to start its program cycle. A busy flag from the buffer makes the block refuse its select byte, so a master can poll by repeating the select until it is acknowledged. A write-enable input decides whether data bytes are forwarded. The whole controller stays silent until the mode flag is raised.

Top module: `tw_mem_slave`

## Requirements
- R1: While `bidir_en_i` is 0 the block never drives the data line and forwards no write; a select byte sent in that state gets no acknowledge.
- R2: The data line is sampled on a rising clock-line edge; the block changes `sda_oe_o` only while the synchronized clock line is low, one cycle after the falling edge is seen.
- R3: The first byte after START is taken MSB first; it is accepted when bits 7:4 equal 1010, bits 3:1 are ignored and bit 0 selects read (1) or write (0). An accepted select is acknowledged by a low data line during the ninth clock; any other value is not acknowledged and the block ignores the bus until the next START.
- R4: While `busy_i` is 1 at the end of a select byte, that select is not acknowledged.
- R5: After a write select the address byte and each data byte are acknowledged; each data byte received with `wr_en_i` at 1 gives one `wr_valid_o` pulse carrying the pointer value and the byte.
- R6: A data byte received with `wr_en_i` at 0 is still acknowledged but gives no `wr_valid_o` pulse, and memory content stays unchanged.
- R7: During a write the pointer advances in its 3 low bits only, wrapping inside the same 8-byte row.
- R8: A STOP or repeated START after at least one forwarded byte gives exactly one one-cycle `wr_commit_o` pulse; a transfer that forwarded nothing gives none.
- R9: The pointer resets to 0 and is shared by reads and writes; a read select outputs the byte at the pointer MSB first and then increments the pointer.
- R10: A random read is an address-only write followed by a repeated START and a read select; it returns the byte at the loaded address.
- R11: While the master acknowledges, consecutive bytes follow, and the pointer wraps from 7Fh to 00h.
- R12: When the master does not acknowledge a read byte, the block releases the data line and ignores further clocks until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bidir_en_i | input | 1 | Mode flag; the controller acts only while it is 1 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wr_en_i | input | 1 | 1 lets data bytes reach the page buffer |
| busy_i | input | 1 | Program cycle in progress in the page buffer |
| rd_addr_o | output | 7 | Pointer driven to the memory read port |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, combinational |
| wr_valid_o | output | 1 | One-cycle strobe for a forwarded write byte |
| wr_addr_o | output | 7 | Address of the forwarded byte |
| wr_data_o | output | 8 | Forwarded byte |
| wr_commit_o | output | 1 | One-cycle strobe that starts the program cycle |

## Verification
The select-byte decision can meet the busy flag in the same cycle: the block judges the byte on the falling clock edge after bit 0, and the bench holds `busy_i` high across that edge so that the acknowledge sampled in the ninth clock must read high. A second pairing is the pointer step and the read-port fetch on a sequential read at 7Fh, where the byte for 7Fh is loaded and the pointer wraps to 00h in one cycle. The bench provokes this with a three-byte read from 7Eh and compares the bytes with its own memory image.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PAGE_W   = 3;
  localparam int unsigned ID_W     = 4;
  localparam int unsigned SYNC_LEN = 2;
  localparam logic [ID_W-1:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_byte_shift.sv
module tw_byte_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_en_i,
  input  logic         rx_bit_i,
  input  logic         tx_load_i,
  input  logic [W-1:0] tx_val_i,
  input  logic         tx_shift_i,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_o <= '0;
      tx_o <= '0;
    end else begin
      if (rx_en_i) rx_o <= {rx_o[W-2:0], rx_bit_i};
      if (tx_load_i)       tx_o <= tx_val_i;
      else if (tx_shift_i) tx_o <= {tx_o[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int unsigned AW = 7,
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          page_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] page_next;

  // row bits held, column bits wrap
  assign page_next = {addr_o[AW-1:PW], addr_o[PW-1:0] + PW'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= page_i ? page_next : addr_o + AW'(1);
  end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int unsigned ADDR_W = tw_pkg::ADDR_W,
  parameter int unsigned DATA_W = tw_pkg::DATA_W,
  parameter int unsigned PAGE_W = tw_pkg::PAGE_W,
  parameter int unsigned SYNC_LEN = tw_pkg::SYNC_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bidir_en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wr_en_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_commit_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [DATA_W-1:0] rx_byte, tx_byte;
  logic [ADDR_W-1:0] addr;

  state_e            state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_ph, oe_q, rw_q, wr_pend, mack_q;
  logic              wr_valid_q, commit_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic live, rx_state, byte_end, ack_end, sel_ok, rd_begin;
  logic addr_load, step_page, tx_shift;

  tw_line_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  always_comb begin
    live      = bidir_en_i && !bus_start && !bus_stop;
    rx_state  = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
    byte_end  = live && rx_state && scl_fall && !ack_ph && (bit_cnt == LAST_BIT);
    ack_end   = live && rx_state && scl_fall && ack_ph;
    sel_ok    = (rx_byte[DATA_W-1 -: ID_W] == DEV_ID) && !busy_i;
    rd_begin  = (ack_end && (state == ST_DEV) && rw_q) ||
                (live && (state == ST_RACK) && scl_fall && mack_q);
    addr_load = byte_end && (state == ST_ADDR);
    step_page = byte_end && (state == ST_WDATA);
    tx_shift  = live && (state == ST_RDATA) && scl_fall && (bit_cnt != LAST_BIT);
  end

  tw_byte_shift #(.W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (live && scl_rise),
    .rx_bit_i   (sda_s),
    .tx_load_i  (rd_begin),
    .tx_val_i   (rd_data_i),
    .tx_shift_i (tx_shift),
    .rx_o       (rx_byte),
    .tx_o       (tx_byte)
  );

  tw_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i (rx_byte[ADDR_W-1:0]),
    .step_i     (step_page || rd_begin),
    .page_i     (step_page),
    .addr_o     (addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      ack_ph     <= 1'b0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      wr_pend    <= 1'b0;
      mack_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      if (!bidir_en_i) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        oe_q    <= 1'b0;
        wr_pend <= 1'b0;
      end else if (bus_start || bus_stop) begin
        commit_q <= wr_pend;
        wr_pend  <= 1'b0;
        state    <= bus_start ? ST_DEV : ST_IDLE;
        bit_cnt  <= '0;
        ack_ph   <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        if (scl_rise && ((rx_state && !ack_ph) || (state == ST_RDATA)))
          bit_cnt <= bit_cnt + CNT_W'(1);
        if (scl_rise && (state == ST_RACK))
          mack_q <= ~sda_s;

        if (byte_end) begin
          unique case (state)
            ST_DEV: begin
              if (sel_ok) begin
                ack_ph <= 1'b1;
                oe_q   <= 1'b1;
                rw_q   <= rx_byte[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              ack_ph <= 1'b1;
              oe_q   <= 1'b1;
            end
            default: begin
              ack_ph <= 1'b1;
              oe_q   <= 1'b1;
              if (wr_en_i) begin
                wr_valid_q <= 1'b1;
                wr_addr_q  <= addr;
                wr_data_q  <= rx_byte;
                wr_pend    <= 1'b1;
              end
            end
          endcase
        end

        if (ack_end) begin
          ack_ph  <= 1'b0;
          bit_cnt <= '0;
          oe_q    <= rd_begin ? ~rd_data_i[DATA_W-1] : 1'b0;
          unique case (state)
            ST_DEV:  state <= rw_q ? ST_RDATA : ST_ADDR;
            default: state <= ST_WDATA;
          endcase
        end

        if ((state == ST_RDATA) && scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            oe_q  <= 1'b0;
            state <= ST_RACK;
          end else begin
            oe_q <= ~tx_byte[DATA_W-2];
          end
        end

        if ((state == ST_RACK) && scl_fall) begin
          if (mack_q) begin
            state   <= ST_RDATA;
            bit_cnt <= '0;
            oe_q    <= ~rd_data_i[DATA_W-1];
          end else begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign rd_addr_o   = addr;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bidir_en_i,
  input logic          wr_en_i,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          wr_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_commit_o
);
  logic          have_last;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (wr_commit_o || !bidir_en_i) begin
      have_last <= 1'b0;
    end else if (wr_valid_o) begin
      have_last <= 1'b1;
      last_addr <= wr_addr_o;
    end
  end

  a_r2_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bidir_en_i && $past(bidir_en_i) && (sda_oe_o != $past(sda_oe_o))) |-> !scl_s);

  a_r1_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bidir_en_i |=> (!sda_oe_o && !wr_valid_o));

  a_r6_gated_by_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(wr_en_i));

  a_r7_row_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && have_last) |->
      ((wr_addr_o[AW-1:PW] == last_addr[AW-1:PW]) &&
       (wr_addr_o[PW-1:0] == last_addr[PW-1:0] + PW'(1))));

  a_r8_commit_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);

  a_r5_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.AW(ADDR_W), .PW(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bidir_en_i  (bidir_en_i),
  .wr_en_i     (wr_en_i),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .wr_valid_o  (wr_valid_o),
  .wr_addr_o   (wr_addr_o),
  .wr_commit_o (wr_commit_o)
);

// File: tb/tw_mem_slave_test.sv
`timescale 1ns/1ps
module tw_mem_slave_test;
  localparam int HALF = 10;

  typedef struct packed {
    logic       is_rd;
    logic [6:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 7'h05, 8'h3C},
    '{1'b0, 7'h7F, 8'hA5},
    '{1'b1, 7'h05, 8'h00},
    '{1'b1, 7'h7F, 8'h00},
    '{1'b0, 7'h40, 8'h00},
    '{1'b1, 7'h40, 8'h00},
    '{1'b1, 7'h11, 8'h00},
    '{1'b0, 7'h11, 8'hFF},
    '{1'b1, 7'h11, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bidir_en = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_en = 1'b1;
  logic busy = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic wr_valid, wr_commit;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] rd_buf [8];

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int commit_cnt = 0;
  int r2_viol = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  tw_mem_slave uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bidir_en_i  (bidir_en),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .wr_en_i     (wr_en),
    .busy_i      (busy),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit)
  );

  // page buffer and array model behind the controller
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 37) ^ 8'h5A;
    end else if (wr_valid) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always @(posedge clk) begin
    if (wr_valid) wr_cnt++;
    if (wr_commit) commit_cnt++;
  end

  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl) r2_viol++;
    oe_prev <= sda_oe;
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl = 1'b1;   hp();
    sda_m = 1'b0; hp();
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl = 1'b1;   hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hp();
    scl = 1'b1; hp();
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hp();
    scl = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    b = sda_line;
    repeat (HALF / 2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] seed,
                          input logic [2:0] dc, output logic all_ack);
    logic ack;
    all_ack = 1'b1;
    bus_start();
    send_byte({4'b1010, dc, 1'b0}, ack); all_ack &= ack;
    send_byte({1'b0, a}, ack);          all_ack &= ack;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      logic [6:0] ea;
      d  = seed + 8'(k * 17);
      ea = {a[6:3], a[2:0] + 3'(k)};
      send_byte(d, ack); all_ack &= ack;
      if (wr_en) exp_mem[ea] = d;
    end
    bus_stop();
    hp();
  endtask

  task automatic do_rand_read(input logic [6:0] a, input int n, output logic all_ack);
    logic ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(8'hA4, ack);     all_ack &= ack;
    send_byte({1'b0, a}, ack); all_ack &= ack;
    bus_start();
    send_byte(8'hAB, ack);     all_ack &= ack;
    for (int k = 0; k < n; k++) recv_byte(rd_buf[k], k != n - 1);
    bus_stop();
    hp();
  endtask

  task automatic do_cur_read(output logic all_ack);
    logic ack;
    bus_start();
    send_byte(8'hA1, ack);
    all_ack = ack;
    recv_byte(rd_buf[0], 1'b0);
    bus_stop();
    hp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic ok;
    int w0, c0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 37) ^ 8'h5A;
    repeat (5) @(negedge clk);
    // reset state
    chk(sda_oe == 1'b0, "R1 reset oe", 32'(sda_oe), 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R8 reset strobes", 32'({wr_valid, wr_commit}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_addr == 7'h00, "R9 reset pointer", 32'(rd_addr), 0);

    // R1: disabled, select refused and no forwarding
    w0 = wr_cnt;
    do_write(7'h03, 1, 8'h77, 3'b000, ok);
    chk(ok == 1'b0, "R1 select while disabled", 32'(ok), 0);
    chk(wr_cnt == w0, "R1 no write while disabled", wr_cnt, w0);
    exp_mem[7'h03] = 8'(3 * 37) ^ 8'h5A;
    bidir_en = 1'b1;
    hp();

    // vector table: byte writes and random reads (R3 R5 R8 R10)
    for (int v = 0; v < 9; v++) begin
      if (!VEC[v].is_rd) begin
        w0 = wr_cnt; c0 = commit_cnt;
        do_write(VEC[v].addr, 1, VEC[v].data, 3'(v), ok);
        chk(ok, "R3 R5 write acks", 32'(ok), 1);
        chk(wr_cnt == w0 + 1, "R5 one forwarded byte", wr_cnt, w0 + 1);
        chk(commit_cnt == c0 + 1, "R8 commit after stop", commit_cnt, c0 + 1);
      end else begin
        do_rand_read(VEC[v].addr, 1, ok);
        chk(ok, "R10 random read acks", 32'(ok), 1);
        chk(rd_buf[0] == exp_mem[VEC[v].addr], "R10 random read data",
            32'(rd_buf[0]), 32'(exp_mem[VEC[v].addr]));
      end
    end

    // R3: wrong identifier, then following byte ignored
    begin
      logic ack;
      bus_start();
      send_byte(8'hB0, ack);
      chk(ack == 1'b0, "R3 wrong id refused", 32'(ack), 0);
      send_byte(8'h00, ack);
      chk(ack == 1'b0, "R3 ignored until start", 32'(ack), 0);
      bus_stop();
      hp();
    end

    // R4: busy refuses select
    busy = 1'b1;
    begin
      logic ack;
      bus_start();
      send_byte(8'hA0, ack);
      chk(ack == 1'b0, "R4 busy select", 32'(ack), 0);
      bus_stop();
      hp();
    end
    busy = 1'b0;

    // R6: write inhibited
    wr_en = 1'b0;
    w0 = wr_cnt; c0 = commit_cnt;
    do_write(7'h20, 2, 8'h11, 3'b101, ok);
    chk(ok, "R6 inhibited still acked", 32'(ok), 1);
    chk(wr_cnt == w0, "R6 nothing forwarded", wr_cnt, w0);
    chk(commit_cnt == c0, "R8 no commit when nothing forwarded", commit_cnt, c0);
    wr_en = 1'b1;
    do_rand_read(7'h20, 1, ok);
    chk(rd_buf[0] == exp_mem[7'h20], "R6 memory unchanged", 32'(rd_buf[0]), 32'(exp_mem[7'h20]));

    // R7: page write crossing the row end
    w0 = wr_cnt; c0 = commit_cnt;
    do_write(7'h0E, 4, 8'hC0, 3'b011, ok);
    chk(ok, "R5 page acks", 32'(ok), 1);
    chk(wr_cnt == w0 + 4, "R5 four forwarded", wr_cnt, w0 + 4);
    chk(commit_cnt == c0 + 1, "R8 single commit", commit_cnt, c0 + 1);

    // R9: pointer continues from the write (0Ah), then 0Bh
    do_cur_read(ok);
    chk(ok, "R9 read select ack", 32'(ok), 1);
    chk(rd_buf[0] == exp_mem[7'h0A], "R9 current read after write", 32'(rd_buf[0]), 32'(exp_mem[7'h0A]));
    do_cur_read(ok);
    chk(rd_buf[0] == exp_mem[7'h0B], "R9 current read increments", 32'(rd_buf[0]), 32'(exp_mem[7'h0B]));

    // R7 R11: read back the row sequentially
    do_rand_read(7'h08, 8, ok);
    for (int k = 0; k < 8; k++)
      chk(rd_buf[k] == exp_mem[7'h08 + 7'(k)], "R7 row contents",
          32'(rd_buf[k]), 32'(exp_mem[7'h08 + 7'(k)]));

    // R11: wrap from 7Fh to 00h
    do_rand_read(7'h7E, 3, ok);
    chk(rd_buf[0] == exp_mem[7'h7E], "R11 byte 7E", 32'(rd_buf[0]), 32'(exp_mem[7'h7E]));
    chk(rd_buf[1] == exp_mem[7'h7F], "R11 byte 7F", 32'(rd_buf[1]), 32'(exp_mem[7'h7F]));
    chk(rd_buf[2] == exp_mem[7'h00], "R11 wrap to 00", 32'(rd_buf[2]), 32'(exp_mem[7'h00]));

    // R12: no master ack, then bus left alone
    begin
      logic ack;
      logic [7:0] v;
      bus_start();
      send_byte(8'hA0, ack);
      send_byte(8'h30, ack);
      bus_start();
      send_byte(8'hA1, ack);
      recv_byte(v, 1'b0);
      chk(v == exp_mem[7'h30], "R12 last byte", 32'(v), 32'(exp_mem[7'h30]));
      recv_byte(v, 1'b1);
      chk(v == 8'hFF, "R12 released after nack", 32'(v), 32'hFF);
      bus_stop();
      hp();
    end

    chk(r2_viol == 0, "R2 oe changed with scl high", r2_viol, 0);
    summary();
  end
endmodule